// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a bus-programmed watchdog. A 16-bit up-counter advances on strobes from up to three clock-enable sources, thinned out by a programmable power-of-four prescaler. When the running count reaches a programmed 16-bit compare value, the block raises a single-cycle system reset request and parks the counter there. Software stays alive by writing zero to the counter before the compare value is reached.

Four word registers sit on a simple synchronous register bus. Reads are combinational from the current register state. A write lands on the next rising clock edge. The usual bring-up is: stop the counter, program the divider with no source selected, load the compare value, clear the counter, select a source together with the divider, and then start the counter.

Top module: `guard_timer`

## Requirements
- R1: After synchronous reset, every register reads zero and `rst_req` is low.
- R2: Readback works as follows. Address 0x0 returns the compare value (16 bits). Address 0x4 returns the run bit in bit 0. Address 0x8 returns the counter. Address 0xC returns control, with the source mask in bits [2:0] and the divider code in bits [5:3]. Unused bits read zero, and any other address reads zero.
- R3: The counter advances by exactly one per prescaler period. A period is made of strobes on `src_stb` lanes whose mask bit is set (bit 0, bit 1 or bit 2 of control). Strobes on unselected lanes, strobes with an empty mask and strobes while stopped have no effect.
- R4: Divider code n, for n from 0 to 5, needs 4^n qualifying strobes per increment. Codes 6 and 7 behave as code 5, which needs 1024 strobes.
- R5: A write to address 0x8 loads the counter with the written value, so writing zero is the keep-alive action. The write also discards any partial prescaler progress.
- R6: Writing 0 to bit 0 of address 0x4 freezes the counter at its value and discards partial prescaler progress. Writing 1 resumes counting.
- R7: While running, the counter reaching the compare value raises `rst_req` for exactly one cycle, and the counter then holds. A new pulse needs the match to be left (for example by a keep-alive) and reached again.
- R8: A counter loaded above the compare value counts through 0xFFFF, wraps to 0x0000 and then continues up to the compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| src_stb | input | 3 | Clock-enable strobes: bit 0 peripheral, bit 1 low-speed real-time, bit 2 external |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The hardest behaviour to reach from the ports is the prescaler's hidden partial count. It shows only as an increment that comes late or early. The stimulus sets a divide-by-4 period, leaves it part-way through, and then either kicks the counter or stops the block. It then counts the strobes needed for the next increment. It also walks every divider code up to the 1024 boundary, including codes 6 and 7. A behavioural model compares the readback and the reset pulse on every clock.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;

    localparam int unsigned GT_DATA_W    = 16;
    localparam int unsigned GT_ADDR_W    = 4;
    localparam int unsigned GT_NSRC      = 3;
    localparam int unsigned GT_DIVSEL_W  = 3;
    localparam int unsigned GT_MAX_CODE  = 5;
    localparam int unsigned GT_PRE_W     = 2 * GT_MAX_CODE;
    localparam int unsigned GT_CTRL_W    = GT_NSRC + GT_DIVSEL_W;

    localparam logic [GT_ADDR_W-1:0] OFS_CMP  = 4'h0;
    localparam logic [GT_ADDR_W-1:0] OFS_RUN  = 4'h4;
    localparam logic [GT_ADDR_W-1:0] OFS_CNT  = 4'h8;
    localparam logic [GT_ADDR_W-1:0] OFS_CTRL = 4'hC;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CMP,
        SEL_RUN,
        SEL_CNT,
        SEL_CTRL
    } reg_sel_e;

    typedef struct packed {
        logic [GT_DIVSEL_W-1:0] div;
        logic [GT_NSRC-1:0]     src;
    } ctrl_t;

    function automatic reg_sel_e decode(input logic [GT_ADDR_W-1:0] a);
        reg_sel_e s;
        unique case (a)
            OFS_CMP:  s = SEL_CMP;
            OFS_RUN:  s = SEL_RUN;
            OFS_CNT:  s = SEL_CNT;
            OFS_CTRL: s = SEL_CTRL;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    // Terminal value of the prescaler for a divider code: 4^code - 1,
    // with codes above the largest one clamped.
    function automatic logic [GT_PRE_W-1:0] pre_last(input logic [GT_DIVSEL_W-1:0] code);
        int unsigned      c;
        logic [GT_PRE_W:0] one_hot;
        c = (int'(code) > int'(GT_MAX_CODE)) ? GT_MAX_CODE : int'(code);
        one_hot = '0;
        one_hot[2*c] = 1'b1;
        return GT_PRE_W'(one_hot - 1'b1);
    endfunction

endpackage

// File: rtl/guard_timer_regs.sv
module guard_timer_regs
    import guard_timer_pkg::*;
#(
    parameter int unsigned DATA_W = GT_DATA_W,
    parameter int unsigned ADDR_W = GT_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cnt_q,
    output logic [DATA_W-1:0] cmp_q,
    output logic              run_q,
    output ctrl_t             ctrl_q,
    output logic              cnt_ld,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned PAD_RUN  = DATA_W - 1;
    localparam int unsigned PAD_CTRL = DATA_W - GT_CTRL_W;

    reg_sel_e sel;

    always_comb sel = decode(addr);

    assign cnt_ld = wr && (sel == SEL_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q  <= '0;
            run_q  <= 1'b0;
            ctrl_q <= '0;
        end else if (wr) begin
            case (sel)
                SEL_CMP:  cmp_q  <= wdata;
                SEL_RUN:  run_q  <= wdata[0];
                SEL_CTRL: ctrl_q <= ctrl_t'(wdata[GT_CTRL_W-1:0]);
                default:  ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CMP:  rdata = cmp_q;
            SEL_RUN:  rdata = {{PAD_RUN{1'b0}}, run_q};
            SEL_CNT:  rdata = cnt_q;
            SEL_CTRL: rdata = {{PAD_CTRL{1'b0}}, ctrl_q};
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/guard_timer_presc.sv
module guard_timer_presc
    import guard_timer_pkg::*;
#(
    parameter int unsigned NSRC  = GT_NSRC,
    parameter int unsigned PRE_W = GT_PRE_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   run,
    input  logic                   clr,
    input  logic                   hold,
    input  logic [NSRC-1:0]        src_sel,
    input  logic [NSRC-1:0]        src_stb,
    input  logic [GT_DIVSEL_W-1:0] div_code,
    output logic                   step,
    output logic [PRE_W-1:0]       pre_q
);

    logic [NSRC-1:0]  lane_hit;
    logic             src_tick;
    logic [PRE_W-1:0] last;
    logic             wrap;

    for (genvar i = 0; i < NSRC; i++) begin : g_lane
        assign lane_hit[i] = src_sel[i] & src_stb[i];
    end

    assign src_tick = |lane_hit;
    assign last     = pre_last(div_code);
    assign wrap     = (pre_q == last);
    assign step     = run && !clr && !hold && src_tick && wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (!run || clr) begin
            pre_q <= '0;
        end else if (!hold && src_tick) begin
            pre_q <= wrap ? '0 : pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/guard_timer_count.sv
module guard_timer_count
    import guard_timer_pkg::*;
#(
    parameter int unsigned DATA_W = GT_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [DATA_W-1:0] cmp,
    input  logic              ld,
    input  logic [DATA_W-1:0] ld_val,
    input  logic              step,
    output logic [DATA_W-1:0] cnt_q,
    output logic              match,
    output logic              fire
);

    logic match_q;

    assign match = run && (cnt_q == cmp);
    assign fire  = match && !match_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            match_q <= 1'b0;
        end else begin
            match_q <= match;
            if (ld) begin
                cnt_q <= ld_val;
            end else if (step) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/guard_timer.sv
module guard_timer
    import guard_timer_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [GT_ADDR_W-1:0] bus_addr,
    input  logic [GT_DATA_W-1:0] bus_wdata,
    output logic [GT_DATA_W-1:0] bus_rdata,
    input  logic [GT_NSRC-1:0]   src_stb,
    output logic                 rst_req
);

    logic [GT_DATA_W-1:0] cmp_q;
    logic [GT_DATA_W-1:0] cnt_q;
    logic                 run_q;
    ctrl_t                ctrl_q;
    logic                 cnt_ld;
    logic                 step;
    logic                 match;
    logic [GT_PRE_W-1:0]  pre_q;

    guard_timer_regs #(
        .DATA_W (GT_DATA_W),
        .ADDR_W (GT_ADDR_W)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .cnt_q  (cnt_q),
        .cmp_q  (cmp_q),
        .run_q  (run_q),
        .ctrl_q (ctrl_q),
        .cnt_ld (cnt_ld),
        .rdata  (bus_rdata)
    );

    guard_timer_presc #(
        .NSRC  (GT_NSRC),
        .PRE_W (GT_PRE_W)
    ) u_presc (
        .clk      (clk),
        .rst      (rst),
        .run      (run_q),
        .clr      (cnt_ld),
        .hold     (match),
        .src_sel  (ctrl_q.src),
        .src_stb  (src_stb),
        .div_code (ctrl_q.div),
        .step     (step),
        .pre_q    (pre_q)
    );

    guard_timer_count #(
        .DATA_W (GT_DATA_W)
    ) u_count (
        .clk    (clk),
        .rst    (rst),
        .run    (run_q),
        .cmp    (cmp_q),
        .ld     (cnt_ld),
        .ld_val (bus_wdata),
        .step   (step),
        .cnt_q  (cnt_q),
        .match  (match),
        .fire   (rst_req)
    );

endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk
    import guard_timer_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 run_q,
    input logic [GT_DATA_W-1:0] cnt_q,
    input logic [GT_DATA_W-1:0] cmp_q,
    input logic                 cnt_ld,
    input logic [GT_DATA_W-1:0] bus_wdata,
    input logic [GT_PRE_W-1:0]  pre_q,
    input logic                 rst_req
);

    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R7
    pulse_match_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (run_q && cnt_q == cmp_q));

    // R7
    hold_at_match_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && cnt_q == cmp_q && !cnt_ld) |=> $stable(cnt_q));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !cnt_ld) |=> $stable(cnt_q));

    // R6
    pre_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !run_q |=> (pre_q == '0));

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_ld |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

    // R5
    load_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_ld |=> (cnt_q == $past(bus_wdata) && pre_q == '0));

endmodule

bind guard_timer guard_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .run_q     (run_q),
    .cnt_q     (cnt_q),
    .cmp_q     (cmp_q),
    .cnt_ld    (cnt_ld),
    .bus_wdata (bus_wdata),
    .pre_q     (pre_q),
    .rst_req   (rst_req)
);

// File: tb/guard_timer_tb.sv
module guard_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [2:0]  src_stb = 3'b000;
    logic        rst_req;

    int tests = 0;
    int fails = 0;
    int pulses = 0;

    always #4 clk = ~clk;

    guard_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_stb   (src_stb),
        .rst_req   (rst_req)
    );

    // ---------------- behavioural reference ----------------
    logic [15:0] m_cmp, m_cnt;
    logic [5:0]  m_ctrl;
    logic        m_en, m_mprev;
    int          m_pre;

    function automatic int div_len(input int code);
        return (code >= 5) ? 1024 : (1 << (2 * code));
    endfunction

    function automatic logic [15:0] m_read(input logic [3:0] a);
        case (a)
            4'h0:    return m_cmp;
            4'h4:    return {15'b0, m_en};
            4'h8:    return m_cnt;
            4'hC:    return {10'b0, m_ctrl};
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic m_req();
        return m_en && (m_cnt == m_cmp) && !m_mprev;
    endfunction

    always @(posedge clk) begin
        logic        now_match, tick, cw;
        logic [15:0] ncnt;
        int          npre;
        if (rst) begin
            m_cmp = 0; m_cnt = 0; m_ctrl = 0; m_en = 0; m_mprev = 0; m_pre = 0;
        end else begin
            now_match = m_en && (m_cnt == m_cmp);
            tick      = |(m_ctrl[2:0] & src_stb);
            cw        = bus_wr && bus_addr == 4'h8;
            ncnt      = m_cnt;
            npre      = m_pre;
            if (!m_en || cw) begin
                npre = 0;
            end else if (!now_match && tick) begin
                if (m_pre == div_len(int'(m_ctrl[5:3])) - 1) begin
                    npre = 0;
                    ncnt = m_cnt + 16'd1;
                end else begin
                    npre = m_pre + 1;
                end
            end
            if (cw) ncnt = bus_wdata;
            if (bus_wr && bus_addr == 4'h0) m_cmp  = bus_wdata;
            if (bus_wr && bus_addr == 4'h4) m_en   = bus_wdata[0];
            if (bus_wr && bus_addr == 4'hC) m_ctrl = bus_wdata[5:0];
            m_cnt   = ncnt;
            m_pre   = npre;
            m_mprev = now_match;
        end
    end

    // ---------------- checking ----------------
    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (!rst) begin
            check(rst_req === m_req(), "R7 rst_req vs model", int'(rst_req), int'(m_req()));
            check(bus_rdata === m_read(bus_addr), "R2 rdata vs model",
                  int'(bus_rdata), int'(m_read(bus_addr)));
            if (rst_req) pulses++;
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        @(posedge clk);
        #2;
        check(bus_rdata === exp, tag, int'(bus_rdata), int'(exp));
    endtask

    task automatic strobe(input logic [2:0] mask, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); src_stb = mask;
            @(negedge clk); src_stb = 3'b000;
        end
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        int p0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        rd_chk(4'h0, 16'h0, "R1 compare after reset");
        rd_chk(4'h4, 16'h0, "R1 run after reset");
        rd_chk(4'h8, 16'h0, "R1 counter after reset");
        rd_chk(4'hC, 16'h0, "R1 control after reset");
        check(rst_req === 1'b0, "R1 rst_req after reset", int'(rst_req), 0);

        // R2 readback and masking
        wr_reg(4'hC, 16'hFFFF);
        rd_chk(4'hC, 16'h003F, "R2 control masked to 6 bits");
        wr_reg(4'h4, 16'hFFFE);
        rd_chk(4'h4, 16'h0000, "R2 run bit only bit 0");
        wr_reg(4'h0, 16'hA5C3);
        rd_chk(4'h0, 16'hA5C3, "R2 compare readback");
        rd_chk(4'h2, 16'h0000, "R2 unmapped address");

        // R3 source selection
        wr_reg(4'h0, 16'd100);
        wr_reg(4'hC, 16'h0002);
        wr_reg(4'h8, 16'h0000);
        wr_reg(4'h4, 16'h0001);
        strobe(3'b101, 10);
        rd_chk(4'h8, 16'd0, "R3 unselected lanes ignored");
        strobe(3'b010, 5);
        rd_chk(4'h8, 16'd5, "R3 selected lane counts");
        wr_reg(4'hC, 16'h0000);
        strobe(3'b111, 4);
        rd_chk(4'h8, 16'd5, "R3 empty mask ignored");
        wr_reg(4'hC, 16'h0007);
        strobe(3'b111, 2);
        rd_chk(4'h8, 16'd7, "R3 simultaneous lanes one step");

        // R4 every divider code
        wr_reg(4'h0, 16'hFFFF);
        for (int code = 0; code < 8; code++) begin
            wr_reg(4'hC, 16'((code << 3) | 2));
            wr_reg(4'h8, 16'h0000);
            strobe(3'b010, div_len(code) - 1);
            rd_chk(4'h8, 16'd0, $sformatf("R4 code %0d one short", code));
            strobe(3'b010, 1);
            rd_chk(4'h8, 16'd1, $sformatf("R4 code %0d full period", code));
        end

        // R5 keep-alive clears prescaler
        wr_reg(4'hC, 16'h000A);
        wr_reg(4'h8, 16'h0000);
        strobe(3'b010, 3);
        wr_reg(4'h8, 16'h0000);
        strobe(3'b010, 3);
        rd_chk(4'h8, 16'd0, "R5 partial period discarded");
        strobe(3'b010, 1);
        rd_chk(4'h8, 16'd1, "R5 full period after kick");
        wr_reg(4'h8, 16'h1234);
        rd_chk(4'h8, 16'h1234, "R5 counter load value");

        // R6 stop freezes and clears prescaler
        wr_reg(4'h8, 16'h0000);
        strobe(3'b010, 2);
        wr_reg(4'h4, 16'h0000);
        strobe(3'b010, 10);
        rd_chk(4'h8, 16'd0, "R6 frozen while stopped");
        wr_reg(4'h4, 16'h0001);
        strobe(3'b010, 3);
        rd_chk(4'h8, 16'd0, "R6 partial period discarded");
        strobe(3'b010, 1);
        rd_chk(4'h8, 16'd1, "R6 resumes counting");

        // R7 bring-up order, pulse and hold
        wr_reg(4'h4, 16'h0000);
        wr_reg(4'hC, 16'h0000);
        wr_reg(4'h0, 16'd3);
        wr_reg(4'h8, 16'h0000);
        wr_reg(4'hC, 16'h0002);
        wr_reg(4'h4, 16'h0001);
        p0 = pulses;
        strobe(3'b010, 2);
        check(pulses == p0, "R7 no pulse before match", pulses - p0, 0);
        strobe(3'b010, 1);
        repeat (3) @(negedge clk);
        check(pulses - p0 == 1, "R7 single pulse at match", pulses - p0, 1);
        strobe(3'b010, 5);
        rd_chk(4'h8, 16'd3, "R7 counter holds at compare");
        check(pulses - p0 == 1, "R7 no repeat while held", pulses - p0, 1);
        wr_reg(4'h8, 16'h0000);
        strobe(3'b010, 3);
        repeat (2) @(negedge clk);
        check(pulses - p0 == 2, "R7 new pulse after kick", pulses - p0, 2);

        // R8 wrap past 0xFFFF
        wr_reg(4'h4, 16'h0000);
        wr_reg(4'h0, 16'd2);
        wr_reg(4'h8, 16'hFFFE);
        wr_reg(4'h4, 16'h0001);
        p0 = pulses;
        strobe(3'b010, 2);
        rd_chk(4'h8, 16'h0000, "R8 wrapped to zero");
        check(pulses == p0, "R8 no pulse above compare", pulses - p0, 0);
        strobe(3'b010, 2);
        repeat (2) @(negedge clk);
        check(pulses - p0 == 1, "R8 pulse after wrap", pulses - p0, 1);

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule